// File: doc/BRIEF.md
# Table-Indirect Descriptor Operand Fetcher

This block supplies operands to a bus-sequencer instruction engine that keeps its per-command parameters in a descriptor table in system memory. The table is found through a base-address register loaded at run time, so the instruction stream never has to be patched. For each request the block adds the instruction's offset field to the base. It then reads the descriptor through a single-outstanding request/response read port and hands back the decoded fields together with a one-cycle completion pulse.

There are two modes. A transfer descriptor is two consecutive words: a 24-bit byte count and then a buffer pointer. A select descriptor is one packed word that carries a target ID pattern and the synchronous period and offset. The fetcher reports three kinds of result:
- an illegal instruction, for a misaligned table entry or a zero byte count;
- a bus fault, for an error response from memory;
- a good fetch.

Top module: `tind_fetch`

## Requirements
- R1: The effective address equals `base_addr` plus `req_offset` sign-extended to the address width. It is the address of the first read issued for a request.
- R2: If the effective address has either of its two low bits set, no read is issued. `done` rises one cycle after acceptance with `status` = 2'b01 (illegal), and all operand outputs keep their values.
- R3: In transfer mode (`req_sel` = 0) the first read is the count word at the effective address and the second read is the pointer word at the effective address plus 4. `rd_addr` stays stable while `rd_req` waits for `rd_ack`.
- R4: After a good transfer fetch, `xfer_count` holds bits 23:0 of the count word and `xfer_addr` holds the whole pointer word, with `status` = 2'b00.
- R5: A count word whose bits 23:0 are zero ends the fetch with `status` = 2'b01. It happens whatever bits 31:24 hold. The pointer word is not read and the operand outputs keep their values.
- R6: In select mode (`req_sel` = 1) a single read is made. `sel_target` takes bits 23:16 of the word, `sel_offset` takes bits 11:8, and `status` = 2'b00.
- R7: `sel_sync` is 1 exactly when the fetched synchronous offset is non-zero. `sel_period` shows bits 14:12 of the word when `sel_sync` is 1 and shows 0 (asynchronous) otherwise.
- R8: A read answered with `rd_err` ends the fetch with `status` = 2'b10 (bus fault) and no further read. All operand outputs keep their values, including a count that was fetched before the fault.
- R9: `done` is a one-cycle pulse in the cycle after the edge that sampled the last response (or after acceptance, in the misaligned case). `req_ready` is 1 only while idle, and `req_valid` is ignored while a fetch is in progress.
- R10: After reset: `req_ready` = 1, `rd_req` = 0, `done` = 0, and all operand outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request, taken when `req_ready` is 1 |
| req_ready | output | 1 | Fetcher idle and able to take a request |
| req_sel | input | 1 | 0 = transfer descriptor, 1 = select descriptor |
| req_offset | input | OFS_W (24) | Signed offset field from the instruction |
| base_addr | input | ADDR_W (32) | Run-time table base address |
| rd_req | output | 1 | Memory read request, held until acknowledged |
| rd_addr | output | ADDR_W (32) | Read address |
| rd_ack | input | 1 | Read response strobe |
| rd_data | input | 32 | Read response data |
| rd_err | input | 1 | Read response carries an error |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 good, 01 illegal instruction, 10 bus fault |
| xfer_count | output | COUNT_W (24) | Fetched byte count |
| xfer_addr | output | ADDR_W (32) | Fetched buffer address |
| sel_target | output | 8 | Fetched target ID pattern |
| sel_period | output | 3 | Synchronous period, 0 when asynchronous |
| sel_offset | output | 4 | Synchronous offset |
| sel_sync | output | 1 | Synchronous transfer applies |

## Verification
The bench goes after negative offsets that borrow across the base. A design that zero-extended the offset would read far above the table. It also drives count words that are zero in the count field but not in the upper byte. A design that tested the whole word would start a zero-length transfer instead of flagging it.

Faults on the pointer word come after a good count word. There the trap is a design that commits the count early and leaves a stale pair on the outputs. Requests held valid through a busy fetch, and memory latencies from zero to several cycles, expose a sequencer that re-accepts or samples the response one cycle off. A select word with a zero offset must report asynchronous operation even when its period bits are set.

// File: rtl/tind_pkg.sv
package tind_pkg;

   typedef enum logic [1:0] {
      ST_OK       = 2'd0,
      ST_ILLEGAL  = 2'd1,
      ST_BUSFAULT = 2'd2
   } tind_status_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CNT,
      PH_PTR,
      PH_SEL,
      PH_DONE
   } tind_phase_e;

   localparam int WORD_W     = 32;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int TGT_LSB    = 16;
   localparam int TGT_W      = 8;
   localparam int PER_LSB    = 12;
   localparam int PER_W      = 3;
   localparam int SOF_LSB    = 8;
   localparam int SOF_W      = 4;

endpackage

// File: rtl/tind_addr_gen.sv
module tind_addr_gen #(
   parameter int ADDR_W     = 32,
   parameter int OFS_W      = 24,
   parameter bit OFS_SIGNED = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] ea,
   output logic              misaligned
);
   localparam int EXT_W = ADDR_W - OFS_W;

   logic [ADDR_W-1:0] ofs_ext;

   generate
      if (EXT_W == 0) begin : g_noext
         assign ofs_ext = ofs;
      end else if (OFS_SIGNED) begin : g_sext
         assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
      end else begin : g_zext
         assign ofs_ext = {{EXT_W{1'b0}}, ofs};
      end
   endgenerate

   assign ea         = base + ofs_ext;
   assign misaligned = |ea[1:0];

endmodule

// File: rtl/tind_seq.sv
module tind_seq
   import tind_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sel_mode,
   input  logic              misaligned,
   input  logic [ADDR_W-1:0] ea,
   input  logic              rd_ack,
   input  logic              rd_err,
   input  logic              cnt_zero,
   output logic              idle,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              done,
   output tind_status_e      status,
   output logic              ld_cnt,
   output logic              ld_ptr,
   output logic              ld_sel
);
   tind_phase_e       state_q;
   logic [ADDR_W-1:0] addr_q;
   tind_status_e      status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PH_IDLE;
         addr_q   <= '0;
         status_q <= ST_OK;
      end else begin
         case (state_q)
            PH_IDLE: begin
               if (start) begin
                  addr_q <= ea;
                  if (misaligned) begin
                     state_q  <= PH_DONE;
                     status_q <= ST_ILLEGAL;
                  end else begin
                     state_q <= sel_mode ? PH_SEL : PH_CNT;
                  end
               end
            end
            PH_CNT: begin
               if (rd_ack) begin
                  if (rd_err) begin
                     state_q  <= PH_DONE;
                     status_q <= ST_BUSFAULT;
                  end else if (cnt_zero) begin
                     state_q  <= PH_DONE;
                     status_q <= ST_ILLEGAL;
                  end else begin
                     state_q <= PH_PTR;
                     addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
                  end
               end
            end
            PH_PTR, PH_SEL: begin
               if (rd_ack) begin
                  state_q  <= PH_DONE;
                  status_q <= rd_err ? ST_BUSFAULT : ST_OK;
               end
            end
            PH_DONE: state_q <= PH_IDLE;
            default: state_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      idle    = (state_q == PH_IDLE);
      rd_req  = (state_q == PH_CNT) || (state_q == PH_PTR) || (state_q == PH_SEL);
      rd_addr = addr_q;
      done    = (state_q == PH_DONE);
      status  = status_q;
      ld_cnt  = (state_q == PH_CNT) && rd_ack && !rd_err && !cnt_zero;
      ld_ptr  = (state_q == PH_PTR) && rd_ack && !rd_err;
      ld_sel  = (state_q == PH_SEL) && rd_ack && !rd_err;
   end

endmodule

// File: rtl/tind_fetch.sv
module tind_fetch
   import tind_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int OFS_W       = 24,
   parameter int COUNT_W     = 24,
   parameter bit OFS_SIGNED  = 1'b1,
   parameter bit GATE_PERIOD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_sel,
   input  logic [OFS_W-1:0]   req_offset,
   input  logic [ADDR_W-1:0]  base_addr,
   output logic               rd_req,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic               rd_ack,
   input  logic [31:0]        rd_data,
   input  logic               rd_err,
   output logic               done,
   output logic [1:0]         status,
   output logic [COUNT_W-1:0] xfer_count,
   output logic [ADDR_W-1:0]  xfer_addr,
   output logic [7:0]         sel_target,
   output logic [2:0]         sel_period,
   output logic [3:0]         sel_offset,
   output logic               sel_sync
);
   generate
      if (ADDR_W != WORD_W) begin : g_bad_addr_w
         $error("tind_fetch: ADDR_W must equal the descriptor word width");
      end
      if (OFS_W > ADDR_W || OFS_W < 3) begin : g_bad_ofs_w
         $error("tind_fetch: OFS_W must lie between 3 and ADDR_W");
      end
      if (COUNT_W < 1 || COUNT_W > TGT_LSB + TGT_W) begin : g_bad_cnt_w
         $error("tind_fetch: COUNT_W out of range");
      end
   endgenerate

   logic [ADDR_W-1:0]  ea;
   logic               misaligned;
   logic               idle;
   logic               ld_cnt, ld_ptr, ld_sel;
   logic               cnt_zero;
   tind_status_e       status_e;
   logic [COUNT_W-1:0] cnt_stage_q;
   logic [PER_W-1:0]   per_raw;
   logic [SOF_W-1:0]   sof_raw;
   logic               sof_nz;

   tind_addr_gen #(
      .ADDR_W    (ADDR_W),
      .OFS_W     (OFS_W),
      .OFS_SIGNED(OFS_SIGNED)
   ) i_addr_gen (
      .base      (base_addr),
      .ofs       (req_offset),
      .ea        (ea),
      .misaligned(misaligned)
   );

   tind_seq #(
      .ADDR_W(ADDR_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (req_valid),
      .sel_mode  (req_sel),
      .misaligned(misaligned),
      .ea        (ea),
      .rd_ack    (rd_ack),
      .rd_err    (rd_err),
      .cnt_zero  (cnt_zero),
      .idle      (idle),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .done      (done),
      .status    (status_e),
      .ld_cnt    (ld_cnt),
      .ld_ptr    (ld_ptr),
      .ld_sel    (ld_sel)
   );

   assign req_ready = idle;
   assign status    = status_e;
   assign cnt_zero  = (rd_data[COUNT_W-1:0] == '0);
   assign per_raw   = rd_data[PER_LSB +: PER_W];
   assign sof_raw   = rd_data[SOF_LSB +: SOF_W];
   assign sof_nz    = |sof_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_stage_q <= '0;
         xfer_count  <= '0;
         xfer_addr   <= '0;
      end else begin
         if (ld_cnt) cnt_stage_q <= rd_data[COUNT_W-1:0];
         if (ld_ptr) begin
            xfer_count <= cnt_stage_q;
            xfer_addr  <= rd_data[ADDR_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_target <= '0;
         sel_offset <= '0;
         sel_sync   <= 1'b0;
      end else if (ld_sel) begin
         sel_target <= rd_data[TGT_LSB +: TGT_W];
         sel_offset <= sof_raw;
         sel_sync   <= sof_nz;
      end
   end

   generate
      if (GATE_PERIOD) begin : g_gated_period
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sel_period <= '0;
            else if (ld_sel) sel_period <= sof_nz ? per_raw : '0;
         end
      end else begin : g_raw_period
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sel_period <= '0;
            else if (ld_sel) sel_period <= per_raw;
         end
      end
   endgenerate

endmodule

// File: rtl/tind_fetch_chk.sv
module tind_fetch_chk #(
   parameter int ADDR_W  = 32,
   parameter int COUNT_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               rd_req,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic               rd_ack,
   input logic               rd_err,
   input logic               done,
   input logic [1:0]         status,
   input logic [COUNT_W-1:0] xfer_count,
   input logic [ADDR_W-1:0]  xfer_addr,
   input logic [7:0]         sel_target
);
   // R3: an outstanding read keeps its address until answered
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   // R3: a follow-on read is always one word above the answered one
   p_next_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && !rd_err) |=> (!rd_req || rd_addr == $past(rd_addr) + ADDR_W'(4)));

   // R8: an error response ends the fetch with a bus fault and no more reads
   p_err_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && rd_err) |=> (done && status == 2'd2 && !rd_req));

   // R8, R5, R2: a failed fetch leaves the operand outputs untouched
   p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 2'd0) |->
         ($stable(xfer_count) && $stable(xfer_addr) && $stable(sel_target)));

   // R9: completion is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: no new request is taken while a fetch is in progress
   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || done) |-> !req_ready);

endmodule

bind tind_fetch tind_fetch_chk #(
   .ADDR_W (ADDR_W),
   .COUNT_W(COUNT_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rd_req    (rd_req),
   .rd_addr   (rd_addr),
   .rd_ack    (rd_ack),
   .rd_err    (rd_err),
   .done      (done),
   .status    (status),
   .xfer_count(xfer_count),
   .xfer_addr (xfer_addr),
   .sel_target(sel_target)
);

// File: tb/test_tind_fetch.sv
`timescale 1ns/1ps
module test_tind_fetch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_sel = 1'b0;
   logic [23:0] req_offset = '0;
   logic [31:0] base_addr = '0;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic        rd_ack = 1'b0;
   logic [31:0] rd_data = '0;
   logic        rd_err = 1'b0;
   logic        done;
   logic [1:0]  status;
   logic [23:0] xfer_count;
   logic [31:0] xfer_addr;
   logic [7:0]  sel_target;
   logic [2:0]  sel_period;
   logic [3:0]  sel_offset;
   logic        sel_sync;

   always #2 clk = ~clk;

   tind_fetch i_tind_fetch (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_sel(req_sel), .req_offset(req_offset), .base_addr(base_addr),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .rd_err(rd_err), .done(done), .status(status), .xfer_count(xfer_count),
      .xfer_addr(xfer_addr), .sel_target(sel_target), .sel_period(sel_period),
      .sel_offset(sel_offset), .sel_sync(sel_sync)
   );

   int n_checks = 0;
   int n_fail   = 0;
   string cur_tag = "R10";

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s) %s: actual %h expected %h at %0t", tag, cur_tag, what, act, exp, $time);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0] mem [int unsigned];
   bit          err_at [int unsigned];
   int          lat = 0;
   int          wcnt = 0;
   int          n_reads = 0;

   function automatic logic [31:0] mem_rd(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'h5A00_0000 ^ a;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         rd_ack = 1'b0; rd_err = 1'b0; wcnt = 0;
      end else if (rd_ack) begin
         rd_ack = 1'b0; rd_err = 1'b0; wcnt = 0;
      end else if (rd_req) begin
         if (wcnt >= lat) begin
            rd_ack  = 1'b1;
            rd_data = mem_rd(rd_addr);
            rd_err  = err_at.exists(rd_addr);
         end else begin
            wcnt++;
         end
      end
   end

   always @(posedge clk) if (rst_n && rd_req && rd_ack) n_reads++;

   // ---------------- reference model ----------------
   int          mph = 0;        // 0 idle, 1 count word, 2 pointer word, 3 select word, 4 done
   logic [31:0] m_addr = '0;
   logic [23:0] m_stash = '0;
   logic [1:0]  e_status = 2'd0;
   logic [23:0] e_count = '0;
   logic [31:0] e_xaddr = '0;
   logic [7:0]  e_tgt = '0;
   logic [2:0]  e_per = '0;
   logic [3:0]  e_sof = '0;
   logic        e_sync = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mph = 0; e_count = '0; e_xaddr = '0; e_tgt = '0; e_per = '0; e_sof = '0; e_sync = 1'b0;
      end else begin
         case (mph)
            0: if (req_valid) begin
                  m_addr = base_addr + {{8{req_offset[23]}}, req_offset};
                  if (m_addr % 4 != 0) begin mph = 4; e_status = 2'd1; end
                  else mph = req_sel ? 3 : 1;
               end
            1: if (rd_ack) begin
                  if (rd_err) begin mph = 4; e_status = 2'd2; end
                  else if (rd_data[23:0] == 0) begin mph = 4; e_status = 2'd1; end
                  else begin m_stash = rd_data[23:0]; m_addr = m_addr + 4; mph = 2; end
               end
            2: if (rd_ack) begin
                  mph = 4;
                  if (rd_err) e_status = 2'd2;
                  else begin e_status = 2'd0; e_count = m_stash; e_xaddr = rd_data; end
               end
            3: if (rd_ack) begin
                  mph = 4;
                  if (rd_err) e_status = 2'd2;
                  else begin
                     e_status = 2'd0;
                     e_tgt  = rd_data[23:16];
                     e_sof  = rd_data[11:8];
                     e_sync = (rd_data[11:8] != 0);
                     e_per  = e_sync ? rd_data[14:12] : 3'd0;
                  end
               end
            default: mph = 0;
         endcase
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R9", "req_ready", req_ready, mph == 0);
         chk("R3", "rd_req", rd_req, (mph >= 1 && mph <= 3));
         if (mph >= 1 && mph <= 3) chk("R1", "rd_addr", rd_addr, m_addr);
         chk("R9", "done", done, mph == 4);
         if (mph == 4) chk("R2", "status", status, e_status);
         chk("R4", "xfer_count", xfer_count, e_count);
         chk("R4", "xfer_addr", xfer_addr, e_xaddr);
         chk("R6", "sel_target", sel_target, e_tgt);
         chk("R6", "sel_offset", sel_offset, e_sof);
         chk("R7", "sel_period", sel_period, e_per);
         chk("R7", "sel_sync", sel_sync, e_sync);
      end
   end

   // ---------------- stimulus ----------------
   task automatic do_op(input bit sel, input logic [31:0] base, input logic [23:0] ofs, input bit hold_busy);
      @(negedge clk);
      req_valid = 1'b1; req_sel = sel; base_addr = base; req_offset = ofs;
      n_reads = 0;
      @(negedge clk);
      if (hold_busy) begin
         base_addr = 32'h0000_4000; req_offset = 24'h000010; req_sel = ~sel;
      end else begin
         req_valid = 1'b0;
      end
      for (int i = 0; i < 100 && !done; i++) @(negedge clk);
      req_valid = 1'b0;
      if (!done) chk("R9", "done seen", 1'b0, 1'b1);
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++; n_checks++;
         $display("FAIL R9 watchdog expired: actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_tag = "R10";
      chk("R10", "ready after reset", req_ready, 1'b1);
      chk("R10", "rd_req after reset", rd_req, 1'b0);
      chk("R10", "done after reset", done, 1'b0);
      chk("R10", "count after reset", xfer_count, 24'd0);
      chk("R10", "target after reset", sel_target, 8'd0);

      // R4 / R3: plain transfer
      cur_tag = "R4";
      mem[32'h1020] = 32'h0000_0200; mem[32'h1024] = 32'h8000_4000;
      do_op(1'b0, 32'h1000, 24'h000020, 1'b0);
      chk("R4", "status good", status, 2'd0);
      chk("R4", "count", xfer_count, 24'h000200);
      chk("R4", "pointer", xfer_addr, 32'h8000_4000);
      chk("R3", "two reads", n_reads, 2);

      // R1: negative offset borrows across the base
      cur_tag = "R1";
      lat = 2;
      mem[32'h1FF0] = 32'h00AB_CDEF; mem[32'h1FF4] = 32'h1234_5678;
      do_op(1'b0, 32'h2000, 24'hFFFFF0, 1'b0);
      chk("R1", "count neg ofs", xfer_count, 24'hABCDEF);
      chk("R1", "pointer neg ofs", xfer_addr, 32'h1234_5678);

      // R6: select word
      cur_tag = "R6";
      lat = 1;
      mem[32'h3008] = 32'h0004_3500;
      do_op(1'b1, 32'h3000, 24'h000008, 1'b0);
      chk("R6", "target", sel_target, 8'h04);
      chk("R6", "offset", sel_offset, 4'h5);
      chk("R7", "period sync", sel_period, 3'd3);
      chk("R6", "one read", n_reads, 1);

      // R7: zero synchronous offset means asynchronous
      cur_tag = "R7";
      mem[32'h300C] = 32'h0080_6000;
      do_op(1'b1, 32'h3000, 24'h00000C, 1'b0);
      chk("R7", "sync flag", sel_sync, 1'b0);
      chk("R7", "period gated", sel_period, 3'd0);
      chk("R7", "target async", sel_target, 8'h80);

      // R2: misaligned entry
      cur_tag = "R2";
      do_op(1'b0, 32'h1000, 24'h000022, 1'b0);
      chk("R2", "status illegal", status, 2'd1);
      chk("R2", "no read", n_reads, 0);
      chk("R2", "count held", xfer_count, 24'hABCDEF);

      // R5: zero count with upper byte set
      cur_tag = "R5";
      lat = 0;
      mem[32'h5000] = 32'hFF00_0000;
      do_op(1'b0, 32'h5000, 24'h000000, 1'b0);
      chk("R5", "status illegal", status, 2'd1);
      chk("R5", "pointer not read", n_reads, 1);
      chk("R5", "pointer held", xfer_addr, 32'h1234_5678);

      // R8: fault on pointer word after a good count
      cur_tag = "R8";
      lat = 3;
      mem[32'h6000] = 32'h0000_0077; err_at[32'h6004] = 1'b1;
      do_op(1'b0, 32'h6000, 24'h000000, 1'b0);
      chk("R8", "status fault", status, 2'd2);
      chk("R8", "count held", xfer_count, 24'hABCDEF);
      chk("R8", "pointer held", xfer_addr, 32'h1234_5678);
      // R8: fault on select word
      err_at[32'h6100] = 1'b1;
      do_op(1'b1, 32'h6100, 24'h000000, 1'b0);
      chk("R8", "select fault", status, 2'd2);
      chk("R8", "target held", sel_target, 8'h80);
      chk("R8", "one read", n_reads, 1);

      // R9: request held valid with changing fields while busy
      cur_tag = "R9";
      lat = 1;
      mem[32'h7010] = 32'h0000_0040; mem[32'h7014] = 32'hCAFE_0000;
      do_op(1'b0, 32'h7000, 24'h000010, 1'b1);
      chk("R9", "busy ignored count", xfer_count, 24'h000040);
      chk("R9", "busy ignored ptr", xfer_addr, 32'hCAFE_0000);
      chk("R9", "reads while busy", n_reads, 2);
      @(negedge clk);
      chk("R9", "done drops", done, 1'b0);

      // mixed pattern sweep
      cur_tag = "R4";
      for (int k = 0; k < 12; k++) begin
         logic [31:0] b;
         lat = k % 4;
         b = 32'h0001_0000 + 32'(k * 64);
         mem[b + 32'h8] = 32'(k + 1) << 4;
         mem[b + 32'hC] = 32'hA000_0000 + 32'(k);
         do_op(k[0], b, 24'h000008, 1'b0);
         chk("R4", "sweep status", status, 2'd0);
      end

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule